// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a down-counting interval timer for periodic interrupts, such as the scheduler tick of an operating system. Software stores a reload value, picks a tick source and enables the timer. On each active tick the 24-bit counter steps down by one. When it steps from 1 to 0, the block sets a sticky wrap flag and, if interrupts are enabled, sends a one-cycle interrupt request. On the next tick the counter reloads. With a reload value of n the interrupt period is n+1 ticks. A reload value of 0 keeps the counter at zero and produces no events.

The tick source is either every processor clock cycle or an external reference tick. The reference tick is asynchronous. It passes through a synchronizer and a rising-edge detector, so each rising edge gives one decrement. Software reaches three word registers over a simple synchronous strobe bus with one cycle of read latency. Reading the control/status register clears the wrap flag. Any write to the current-value register sets the counter to zero and clears the flag.

A small state machine sequences the counter. It has three states:
- `ST_OFF`: counting is disabled.
- `ST_ARMED`: cleared by a current-value write and waiting for its first tick.
- `ST_COUNT`: running.

The transitions are:
- OFF→COUNT: the first tick after enable, which loads the reload value.
- ARMED→COUNT: the first tick after a clear, which also loads the reload value.
- COUNT→OFF and ARMED→OFF: enable is cleared.
- any state→ARMED: a current-value write while enabled.
- any state→OFF: a current-value write while disabled.

Top module: `periodic_tick_timer`

## Requirements
- R1: Register map, selected by the word address `bus_addr`:
  - Address 0 is control/status. Bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the source (1 = processor clock, 0 = reference tick), and bit 16 is the read-only wrap flag.
  - Address 1 is the reload value.
  - Address 2 is the current counter value.
  - Address 3 reads as zero.
  - Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R2: After reset, control/status reads 0x00000000, reload and current value read 0, and `tick_irq` is low.
- R3: The first active tick after counting is enabled loads the reload value without setting the flag. Each later tick decrements the counter by one.
- R4: With reload n the counter runs n, n-1, …, 1, 0, n, …. The wrap flag sets only on the step from 1 to 0. A reload of 0 leaves the counter at 0 with no flag.
- R5: The wrap flag stays set until the control/status register is read. That read returns the flag still set, and the flag is then cleared.
- R6: A write of any data to the current-value register sets the counter to 0 and clears the wrap flag. The next active tick loads the reload value without setting the flag.
- R7: `tick_irq` is a one-cycle pulse on each 1-to-0 step, and only while the interrupt-enable bit is 1. In processor-clock mode with reload n, pulses are n+1 cycles apart.
- R8: In reference mode the counter moves exactly once per rising edge of `ref_tick_in`, however long the input stays high.
- R9: Writes to bits 31:24 of the reload and current-value registers are ignored, and those bits read as zero.
- R10: While counting is disabled the counter holds its value. Re-enabling makes the next tick load the reload value.
- R11: When the block is built without a reference tick (`HAS_REF_CLK` = 0), the source bit reads 1 from reset onward and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_in | input | 1 | Asynchronous external reference tick |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench steps the counter in reference mode, one edge at a time, so every counter value it reads is known exactly. It probes these corner cases:
- A design that flagged on the load tick would show the flag right after enable or after a clear.
- A design that wrapped from 0 regardless of the reload value would raise events with a reload of 0.
- A missing edge detector would count many times during one long high pulse on the reference input.
- A design that failed to clear on read or on a current-value write would return a stale flag.

In processor-clock mode the bench measures the spacing of interrupt pulses, which catches off-by-one period errors. With the interrupt disabled it checks that the flag still sets while `tick_irq` stays silent.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_IE_BIT   = 1;
    localparam int CTL_SRC_BIT  = 2;
    localparam int CTL_FLAG_BIT = 16;

    typedef enum logic [1:0] {
        REG_CTL     = 2'd0,
        REG_RELOAD  = 2'd1,
        REG_CURRENT = 2'd2,
        REG_NONE    = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/tick_ref_sync.sv
module tick_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic pulse
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign pulse = sync_q[STAGES-1] & ~prev_q;

    // R8: one rising edge yields a single-cycle pulse
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             inten,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             cur_wr,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             flag_q, irq_q;
    logic             step, do_load, do_dec, wrap_hit;

    assign step = en && tick && !cur_wr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (step) state_d = ST_COUNT;
            ST_ARMED: if (!en) state_d = ST_OFF;
                      else if (step) state_d = ST_COUNT;
            ST_COUNT: if (!en) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
        if (cur_wr) state_d = en ? ST_ARMED : ST_OFF;
    end

    // per-state actions
    always_comb begin
        do_load  = 1'b0;
        do_dec   = 1'b0;
        wrap_hit = 1'b0;
        unique case (state_q)
            ST_OFF, ST_ARMED: do_load = step;
            ST_COUNT: begin
                if (step) begin
                    if (cnt_q == '0) do_load = 1'b1;
                    else begin
                        do_dec   = 1'b1;
                        wrap_hit = (cnt_q == ONE);
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (cur_wr)       cnt_q <= '0;
            else if (do_load) cnt_q <= reload;
            else if (do_dec)  cnt_q <= cnt_q - ONE;

            if (wrap_hit)                flag_q <= 1'b1;
            else if (flag_clr || cur_wr) flag_q <= 1'b0;

            irq_q <= wrap_hit && inten;
        end
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;
    assign irq  = irq_q;

    // R6: a current-value write clears counter and flag
    a_r6_curwr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cnt_q == '0) && !flag_q);
    // R7: request is a single-cycle pulse
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);
    // R7: request coincides with a set flag
    a_r7_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> flag_q);
    // R4: flag rises only when the counter has reached zero
    a_r4_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> (cnt_q == '0));
    // R10: disabled counter holds its value
    a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cur_wr) |=> $stable(cnt_q));

endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int DATA_W      = 32,
    parameter bit HAS_REF_CLK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              flag,
    output logic              en,
    output logic              inten,
    output logic              src_clk,
    output logic [CNT_W-1:0]  reload,
    output logic              cur_wr,
    output logic              flag_clr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam logic SRC_RESET = HAS_REF_CLK ? 1'b0 : 1'b1;

    reg_sel_e          sel_reg;
    logic              wr, rd;
    logic [DATA_W-1:0] ctl_view, rd_mux, rdata_q;
    logic              unused_wdata;

    assign sel_reg  = reg_sel_e'(bus_addr);
    assign wr       = bus_sel && bus_we;
    assign rd       = bus_sel && !bus_we;
    assign cur_wr   = wr && (sel_reg == REG_CURRENT);
    assign flag_clr = rd && (sel_reg == REG_CTL);
    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            inten   <= 1'b0;
            src_clk <= SRC_RESET;
            reload  <= '0;
        end else if (wr) begin
            unique case (sel_reg)
                REG_CTL: begin
                    en      <= bus_wdata[CTL_EN_BIT];
                    inten   <= bus_wdata[CTL_IE_BIT];
                    src_clk <= HAS_REF_CLK ? bus_wdata[CTL_SRC_BIT] : 1'b1;
                end
                REG_RELOAD: reload <= bus_wdata[CNT_W-1:0];
                REG_CURRENT, REG_NONE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        ctl_view               = '0;
        ctl_view[CTL_EN_BIT]   = en;
        ctl_view[CTL_IE_BIT]   = inten;
        ctl_view[CTL_SRC_BIT]  = src_clk;
        ctl_view[CTL_FLAG_BIT] = flag;
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel_reg)
            REG_CTL:     rd_mux = ctl_view;
            REG_RELOAD:  rd_mux = DATA_W'(reload);
            REG_CURRENT: rd_mux = DATA_W'(cnt);
            REG_NONE:    rd_mux = '0;
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R1: read data holds between reads
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata_q));
    // R11: without a reference tick the source stays on processor clock
    a_r11_src_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_REF_CLK |-> src_clk);

endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer #(
    parameter int CNT_W       = 24,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_REF_CLK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);

    logic             en, inten, src_clk, cur_wr, flag_clr, flag;
    logic             ref_pulse, tick;
    logic [CNT_W-1:0] reload, cnt;

    generate
        if (HAS_REF_CLK) begin : g_ref
            tick_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (ref_tick_in),
                .pulse    (ref_pulse)
            );
        end else begin : g_noref
            logic unused_ref;
            assign unused_ref = ref_tick_in;
            assign ref_pulse  = 1'b0;
        end
    endgenerate

    assign tick = src_clk ? 1'b1 : ref_pulse;

    tick_regs #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .HAS_REF_CLK(HAS_REF_CLK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .flag      (flag),
        .en        (en),
        .inten     (inten),
        .src_clk   (src_clk),
        .reload    (reload),
        .cur_wr    (cur_wr),
        .flag_clr  (flag_clr),
        .bus_rdata (bus_rdata)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .inten    (inten),
        .tick     (tick),
        .reload   (reload),
        .cur_wr   (cur_wr),
        .flag_clr (flag_clr),
        .cnt      (cnt),
        .flag     (flag),
        .irq      (tick_irq)
    );

endmodule

// File: tb/periodic_tick_timer_bench.sv
module periodic_tick_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick_in = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, nr_rdata;
    logic        tick_irq, nr_irq;

    always #4 clk = ~clk;   // 125 MHz

    periodic_tick_timer u_periodic_tick_timer (
        .clk(clk), .rst_n(rst_n), .ref_tick_in(ref_tick_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    periodic_tick_timer #(.HAS_REF_CLK(1'b0)) u_periodic_tick_timer_noref (
        .clk(clk), .rst_n(rst_n), .ref_tick_in(ref_tick_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(nr_rdata), .tick_irq(nr_irq)
    );

    typedef struct {
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t   sb_q[$];
    int     checks = 0;
    int     errors = 0;
    bit     done = 0;
    logic   rd_q = 1'b0;
    int     irq_cnt = 0;
    int     cyc = 0;
    int     last_irq = -1;
    int     irq_gap = 0;
    int     min_gap = 1000000;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // driver side
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic [31:0] exp, input string req);
        exp_t e;
        @(negedge clk);
        e.val = exp; e.req = req;
        sb_q.push_back(e);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ref_edge(input int high_cycles);
        @(negedge clk);
        ref_tick_in = 1'b1;
        repeat (high_cycles) @(negedge clk);
        ref_tick_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // monitor side
    always @(posedge clk) rd_q <= bus_sel && !bus_we;

    always @(negedge clk) begin
        exp_t e;
        cyc <= cyc + 1;
        if (rd_q) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R1: read data with no expected item, actual=0x%08h expected=none", bus_rdata);
            end else begin
                e = sb_q.pop_front();
                check(e.req, bus_rdata, e.val);
            end
        end
        if (tick_irq) begin
            irq_cnt <= irq_cnt + 1;
            if (last_irq >= 0) begin
                irq_gap <= cyc - last_irq;
                if (cyc - last_irq < min_gap) min_gap <= cyc - last_irq;
            end
            last_irq <= cyc;
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int irq_base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        check("R2 irq after reset", {31'b0, tick_irq}, 32'h0);
        bus_read(2'd0, 32'h0, "R2 ctl reset");
        check("R11 noref ctl reset", nr_rdata, 32'h4);
        bus_read(2'd1, 32'h0, "R2 reload reset");
        bus_read(2'd2, 32'h0, "R2 current reset");

        // R9 upper byte ignored
        bus_write(2'd1, 32'hAB00_0005);
        bus_read(2'd1, 32'h0000_0005, "R9 reload upper bits");

        // R3 enable in reference mode, irq enabled
        bus_write(2'd0, 32'h3);
        bus_read(2'd0, 32'h3, "R1 ctl fields");
        check("R11 noref src bit stays 1", nr_rdata & 32'h4, 32'h4);
        bus_read(2'd2, 32'h0, "R3 no tick yet");
        ref_edge(2);
        bus_read(2'd2, 32'h5, "R3 first tick loads reload");
        bus_read(2'd0, 32'h3, "R3 no flag on load");
        for (int i = 0; i < 4; i++) ref_edge(2);
        bus_read(2'd2, 32'h1, "R3 decrement");
        irq_base = irq_cnt;
        ref_edge(2);
        bus_read(2'd2, 32'h0, "R4 reach zero");
        check("R7 irq pulse on 1-to-0", irq_cnt - irq_base, 1);
        bus_read(2'd0, 32'h0001_0003, "R5 flag set and returned");
        bus_read(2'd0, 32'h0000_0003, "R5 flag cleared by read");
        ref_edge(2);
        bus_read(2'd2, 32'h5, "R4 wrap to reload");

        // R8 long high pulse counts once
        ref_edge(30);
        bus_read(2'd2, 32'h4, "R8 single count per edge");

        // R6 current write clears counter and flag
        for (int i = 0; i < 4; i++) ref_edge(2);
        bus_write(2'd2, 32'hFFFF_FFFF);
        bus_read(2'd2, 32'h0, "R6 current cleared");
        bus_read(2'd0, 32'h3, "R6 flag cleared by write");
        irq_base = irq_cnt;
        ref_edge(2);
        bus_read(2'd2, 32'h5, "R6 next tick loads");
        bus_read(2'd0, 32'h3, "R6 no flag after load");
        check("R6 no irq on load", irq_cnt - irq_base, 0);

        // R10 disable holds, re-enable reloads
        bus_write(2'd0, 32'h2);
        ref_edge(2);
        ref_edge(2);
        bus_read(2'd2, 32'h5, "R10 hold while off");
        bus_write(2'd1, 32'h9);
        bus_write(2'd0, 32'h3);
        ref_edge(2);
        bus_read(2'd2, 32'h9, "R10 re-enable loads reload");

        // R7 interrupt disabled: flag sets, no pulse
        bus_write(2'd0, 32'h1);
        bus_write(2'd1, 32'h2);
        bus_write(2'd2, 32'h0);
        irq_base = irq_cnt;
        for (int i = 0; i < 3; i++) ref_edge(2);
        bus_read(2'd2, 32'h0, "R7 count reached zero");
        check("R7 no irq while disabled", irq_cnt - irq_base, 0);
        bus_read(2'd0, 32'h0001_0001, "R7 flag without irq");

        // R4 reload of zero
        bus_write(2'd1, 32'h0);
        bus_write(2'd2, 32'h0);
        for (int i = 0; i < 3; i++) ref_edge(2);
        bus_read(2'd2, 32'h0, "R4 zero reload stays zero");
        bus_read(2'd0, 32'h1, "R4 zero reload no flag");

        // R1 unused address
        bus_read(2'd3, 32'h0, "R1 address 3 reads zero");

        // R7 period in processor-clock mode
        bus_write(2'd1, 32'h3);
        bus_write(2'd2, 32'h0);
        irq_base = irq_cnt;
        min_gap = 1000000;
        bus_write(2'd0, 32'h7);
        repeat (40) @(negedge clk);
        bus_write(2'd0, 32'h4);
        check("R7 pulse spacing n+1", irq_gap, 4);
        check("R7 minimum spacing", min_gap, 4);
        check("R7 pulses seen", (irq_cnt - irq_base) >= 8, 1);

        repeat (4) @(negedge clk);
        check("R1 scoreboard drained", sb_q.size(), 0);
        finish_run();
    end

endmodule